// File: doc/BRIEF.md
# Iterative 32-Bit Logical Right Shifter

This block is a multi-cycle execution unit that shifts a 32-bit operand to the right by a variable amount, moving one bit position per clock and filling the vacated high bits with zeros. Each step is an unsigned halving of the operand. A single start pulse loads the operand together with a count byte. A small count byte is taken as the shift amount itself. A larger count byte is a register address, and the matching register value, which the surrounding datapath supplies, provides the amount.

While the shift runs, the unit tracks two flags. The carry holds the bit that dropped out on the latest step. The sticky flag records whether any 1 was lost on an earlier step. When the count is exhausted, the unit raises a one-cycle done pulse. Together with that pulse it presents the result, the carry, the sticky flag, a zero flag and a negative flag. These outputs then hold until the next accepted start. A start that arrives while a shift is in progress is ignored.

Top module: `shr32_iter`

## Requirements
- R1: Each shift step moves the working value right by one position and inserts a 0 at bit 31; the final result equals the operand logically shifted right by the decoded count n.
- R2: A count byte with value 0 to 15 (bits 7:4 all zero) is itself the shift count n.
- R3: A count byte with value 16 to 255 selects the register path: n is bits 4:0 of the register value input, and bits 31:5 of that input are ignored.
- R4: After the final step the carry flag holds operand bit n-1, the last bit shifted out.
- R5: The sticky flag is cleared when a start is accepted. It becomes 1 when a step occurs while the carry is 1, so at the end it equals the OR of operand bits n-2 down to 0 (0 when n is below 2).
- R6: The edge that samples an accepted start loads the unit. For n greater than 0, each of the next n edges performs one step, and done is high in the cycle that follows the n-th edge.
- R7: A count of 0 gives done in the cycle right after the start edge, with the result equal to the operand, carry 0 and sticky 0.
- R8: The zero flag is 1 exactly when the 32-bit result is all zeros. The negative flag is always 0.
- R9: A start pulse received while busy is high has no effect on the running shift or on its result.
- R10: Done lasts a single cycle unless a new start is accepted in that cycle. The result and all flags hold their values until the next accepted start.
- R11: Busy is high while shift steps remain and is low whenever done is high; a start is accepted only when busy is low.
- R12: After reset the result is 0, carry, sticky, busy and done are 0, and the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when not busy |
| operand_i | input | 32 | Value to be shifted |
| cnt_byte_i | input | 8 | Immediate count (0 to 15) or register address (16 to 255) |
| reg_val_i | input | 32 | Register contents for a register-path count |
| result_o | output | 32 | Shift result |
| carry_o | output | 1 | Last bit shifted out |
| sticky_o | output | 1 | A 1 was lost before the final step |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Negative flag, always 0 |
| busy_o | output | 1 | Shift steps remain |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: the end of one operation and the start of the next. A start raised in the cycle where done is high must be accepted. A start raised in the cycle before that, while the last step is still pending and busy is high, must be ignored. The bench runs its whole count sweep back to back, so every new start falls in the previous operation's done cycle, and it checks each result against the operand shifted in bench arithmetic. A separate run drives junk starts on every busy cycle, including the final one, and then checks that the result, the flags and the latency still belong to the first operation.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef struct packed {
    logic carry;
    logic sticky;
    logic zero;
    logic neg;
  } shr_flags_t;
endpackage

// File: rtl/shr_cnt_decode.sv
module shr_cnt_decode #(
  parameter int CNT_BYTE_W = 8,
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 4,
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input  logic [CNT_BYTE_W-1:0] cnt_byte_i,
  input  logic [DATA_W-1:0]     reg_val_i,
  output logic [CNT_W-1:0]      cnt_o
);
  logic             is_imm;
  logic [CNT_W-1:0] imm_cnt;

  assign is_imm = (cnt_byte_i[CNT_BYTE_W-1:IMM_W] == '0);

  generate
    if (CNT_W > IMM_W) begin : g_imm_ext
      assign imm_cnt = {{(CNT_W-IMM_W){1'b0}}, cnt_byte_i[IMM_W-1:0]};
    end else begin : g_imm_trunc
      assign imm_cnt = cnt_byte_i[CNT_W-1:0];
    end
  endgenerate

  // register path keeps only the low count bits
  assign cnt_o = is_imm ? imm_cnt : reg_val_i[CNT_W-1:0];

  logic unused_hi;
  assign unused_hi = ^reg_val_i[DATA_W-1:CNT_W];
endmodule

// File: rtl/shr_core.sv
module shr_core #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] data_o,
  output logic              carry_o,
  output logic              sticky_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  rem_q;
  logic              carry_q, sticky_q, done_q;

  assign busy_o = (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      rem_q    <= '0;
      carry_q  <= 1'b0;
      sticky_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (load_i) begin
      data_q   <= data_i;
      rem_q    <= cnt_i;
      carry_q  <= 1'b0;
      sticky_q <= 1'b0;
      done_q   <= (cnt_i == '0);
    end else if (busy_o) begin
      data_q   <= {1'b0, data_q[DATA_W-1:1]};
      carry_q  <= data_q[0];
      // a 1 already in carry is lost by this further step
      sticky_q <= sticky_q | carry_q;
      rem_q    <= rem_q - 1'b1;
      done_q   <= (rem_q == CNT_W'(1));
    end else begin
      done_q   <= 1'b0;
    end
  end

  assign data_o   = data_q;
  assign carry_o  = carry_q;
  assign sticky_o = sticky_q;
  assign done_o   = done_q;
endmodule

// File: rtl/shr_flags.sv
module shr_flags
  import shr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              sticky_i,
  output shr_flags_t        flags_o
);
  always_comb begin
    flags_o.carry  = carry_i;
    flags_o.sticky = sticky_i;
    flags_o.zero   = (result_i == '0);
    flags_o.neg    = 1'b0;
  end
endmodule

// File: rtl/shr32_iter.sv
module shr32_iter
  import shr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_BYTE_W = 8,
  parameter int IMM_W      = 4,
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [DATA_W-1:0]     operand_i,
  input  logic [CNT_BYTE_W-1:0] cnt_byte_i,
  input  logic [DATA_W-1:0]     reg_val_i,
  output logic [DATA_W-1:0]     result_o,
  output logic                  carry_o,
  output logic                  sticky_o,
  output logic                  zero_o,
  output logic                  neg_o,
  output logic                  busy_o,
  output logic                  done_o
);
  logic [CNT_W-1:0]  cnt_w;
  logic [DATA_W-1:0] data_w;
  logic              carry_w, sticky_w, busy_w, done_w, load_w;
  shr_flags_t        flags_w;

  assign load_w = start_i & ~busy_w;

  shr_cnt_decode #(
    .CNT_BYTE_W (CNT_BYTE_W),
    .DATA_W     (DATA_W),
    .IMM_W      (IMM_W)
  ) u_dec (
    .cnt_byte_i (cnt_byte_i),
    .reg_val_i  (reg_val_i),
    .cnt_o      (cnt_w)
  );

  shr_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_w),
    .data_i   (operand_i),
    .cnt_i    (cnt_w),
    .data_o   (data_w),
    .carry_o  (carry_w),
    .sticky_o (sticky_w),
    .busy_o   (busy_w),
    .done_o   (done_w)
  );

  shr_flags #(
    .DATA_W (DATA_W)
  ) u_flags (
    .result_i (data_w),
    .carry_i  (carry_w),
    .sticky_i (sticky_w),
    .flags_o  (flags_w)
  );

  assign result_o = data_w;
  assign carry_o  = flags_w.carry;
  assign sticky_o = flags_w.sticky;
  assign zero_o   = flags_w.zero;
  assign neg_o    = flags_w.neg;
  assign busy_o   = busy_w;
  assign done_o   = done_w;
endmodule

// File: rtl/shr32_iter_chk.sv
module shr32_iter_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              sticky_o,
  input logic              busy_o,
  input logic              done_o
);
  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> result_o == {1'b0, $past(result_o[DATA_W-1:1])});

  assert_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> carry_o == $past(result_o[0]));

  assert_sticky_acc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> sticky_o == ($past(sticky_o) | $past(carry_o)));

  assert_sticky_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (!sticky_o && !carry_o));

  assert_zero_cnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && cnt_i == '0) |=> (done_o && result_o == $past(operand_i)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(carry_o) && $stable(sticky_o)));

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind shr32_iter shr32_iter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .operand_i (operand_i),
  .cnt_i     (cnt_w),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .sticky_o  (sticky_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/shr32_iter_tb.sv
module shr32_iter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  cnt_byte = '0;
  logic [31:0] reg_val = '0;
  logic [31:0] result;
  logic        carry, sticky, zero, neg, busy, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shr32_iter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .operand_i(operand),
    .cnt_byte_i(cnt_byte), .reg_val_i(reg_val), .result_o(result),
    .carry_o(carry), .sticky_o(sticky), .zero_o(zero), .neg_o(neg),
    .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // caller is just after a negedge; returns at the negedge where done is seen
  task automatic run(input logic [31:0] op, input logic [7:0] cb,
                     input logic [31:0] rv, input bit junk);
    int n, k;
    logic [63:0] exp_res;
    logic exp_c, exp_s;
    string rq;
    n  = (cb < 8'd16) ? int'(cb) : int'(rv[4:0]);
    rq = (cb < 8'd16) ? "R2" : "R3";
    exp_res = {32'd0, op} >> n;
    exp_c = (n == 0) ? 1'b0 : op[n-1];
    exp_s = (n < 2) ? 1'b0 : |(op & ((32'd1 << (n-1)) - 32'd1));
    operand = op; cnt_byte = cb; reg_val = rv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 40) begin
      if (junk) begin
        start = 1'b1; operand = ~op; cnt_byte = 8'd0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(result == exp_res[31:0], junk ? "R9" : rq, "result R1", result, exp_res[31:0]);
    check(k == n, junk ? "R9" : "R6", "latency", k, n);
    check(carry == exp_c, "R4", "carry", {31'd0, carry}, {31'd0, exp_c});
    check(sticky == exp_s, "R5", "sticky", {31'd0, sticky}, {31'd0, exp_s});
    check(zero == (exp_res[31:0] == 0) && !neg, "R8", "zero/neg",
          {30'd0, zero, neg}, {30'd0, exp_res[31:0] == 0, 1'b0});
    check(!busy, "R11", "busy at done", {31'd0, busy}, 32'd0);
    if (n == 0)
      check(result == op && !carry && !sticky, "R7", "zero count",
            result, op);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] ops [6];
    logic [31:0] lfsr;
    logic [31:0] held;
    ops[0] = 32'hFFFF_FFFF; ops[1] = 32'h8000_0001; ops[2] = 32'hA5A5_5A5A;
    ops[3] = 32'h0000_0001; ops[4] = 32'h1234_5678; ops[5] = 32'h0000_8000;
    lfsr = 32'hACE1_1234;

    repeat (3) @(negedge clk);
    // R12 reset state
    check(result == 0 && !carry && !sticky && !busy && !done && zero, "R12",
          "reset state", {result[27:0], carry, sticky, busy, done},
          32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // back-to-back sweeps: each new start lands in the previous done cycle
    for (int i = 0; i < 6; i++) begin
      for (int c = 0; c < 16; c++) run(ops[i], 8'(c), 32'hFFFF_FFE0, 1'b0);
      for (int c = 0; c < 32; c++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        // R3: upper register bits carry junk, address byte varies
        run(ops[i], 8'(16 + ((c * 37 + i) % 240)), {lfsr[31:5], 5'(c)}, 1'b0);
      end
    end

    // R9: junk starts on every busy cycle, including the last step
    run(32'hDEAD_BEEF, 8'd10, 32'd0, 1'b1);
    run(32'hF0F0_F0F1, 8'hFF, 32'h0000_001F, 1'b1);
    run(32'h8000_0000, 8'h10, 32'h0000_0001, 1'b1);

    // R10: done drops and outputs hold while idle
    held = result;
    @(negedge clk);
    check(!done, "R10", "done single cycle", {31'd0, done}, 32'd0);
    repeat (5) @(negedge clk);
    check(result == held && !done && !busy, "R10", "idle hold", result, held);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule